// File: doc/BRIEF.md
# Debug Address Breakpoint Comparator

This block sits beside a CPU core and watches its address bus. When the current address equals one of four programmable 24-bit breakpoint addresses, and that breakpoint is enabled, it raises a break request that puts the core into its debug state. A debug host loads the breakpoints and their enable bits through a byte-wide, write-only register port.

The compared address comes from one of two sources. In full-width mode it is the whole 24-bit bus. In compatibility mode it is an 8-bit base register joined to the low 16 address bits. A match on an opcode fetch breaks at once. A match on any other access is held pending and breaks when the current instruction ends.

Top module: `addr_bp_unit`

## Requirements
- R1: After reset `brk_o` and `hit_o` are 0 and all four breakpoint enables are 0, so an access to any address raises no break.
- R2: A write to register address 4x+0, 4x+1 or 4x+2 (x = 0..3) loads the low, high or upper byte of breakpoint x. Breakpoint x matches only when all 24 bits equal its value {upper, high, low}.
- R3: A write to register address 10h loads the enable vector, with bit x of the data enabling breakpoint x. Data bits 7:4 are dropped. A disabled breakpoint never reports a match.
- R4: With `mode_i` = 1 the compared address is `addr_i[23:0]`, and `mbase_i` has no effect.
- R5: With `mode_i` = 0 the compared address is {`mbase_i`, `addr_i[15:0]`}, and `addr_i[23:16]` has no effect.
- R6: A match on an access with `opfetch_i` = 1 drives `brk_o` high in the next cycle, for one cycle.
- R7: A match on an access with `opfetch_i` = 0 raises no break until `instr_end_i` is seen. `brk_o` then goes high in the cycle after `instr_end_i`. This also holds when `instr_end_i` comes in the same cycle as the match.
- R8: Issuing a break clears the pending state, so a later `instr_end_i` with no new match raises no break.
- R9: When several enabled breakpoints match in one access, `brk_o` pulses once and `hit_o` shows every matching breakpoint.
- R10: Writes to register addresses 03h, 07h, 0Bh, 0Fh and any other unmapped address change no breakpoint and no enable bit.
- R11: In the cycle after an access, `hit_o` holds the vector of enabled breakpoints that matched it. It is 0 after a cycle with `bus_valid_i` low.
- R12: When `bus_valid_i` is low, no match is made, whatever the address and flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Debug register write strobe |
| wr_addr_i | input | 8 | Debug register address |
| wr_data_i | input | 8 | Debug register write data |
| bus_valid_i | input | 1 | The CPU bus carries an access this cycle |
| opfetch_i | input | 1 | The access is the first opcode fetch of an instruction |
| instr_end_i | input | 1 | Pulse at the end of the current instruction |
| mode_i | input | 1 | 1: full 24-bit address, 0: base register plus 16-bit address |
| mbase_i | input | 8 | Base byte used in compatibility mode |
| addr_i | input | 24 | CPU address |
| brk_o | output | 1 | Break request pulse |
| hit_o | output | 4 | Breakpoints that matched the previous access |

## Verification
The bench targets the two address modes with a base byte or upper address byte that differs only in the bits the mode should ignore. A wrong mux would then break on the wrong address or miss the right one. It changes single bytes of the address so that a comparator which drops a byte lane shows as a false hit. It separates fetch and non-fetch matches, and issues a second instruction end after a deferred break. A design that breaks early, or that never clears its pending flag, then shows an extra or missing pulse. Writes to the gap addresses and to near-miss control addresses expose a loose address decode, which would corrupt a breakpoint or drop the enables.

// File: rtl/bp_pkg.sv
package bp_pkg;
  typedef enum logic {
    MODE_BASE16 = 1'b0,
    MODE_FULL24 = 1'b1
  } addr_mode_e;
endpackage

// File: rtl/bp_regs.sv
module bp_regs #(
  parameter int NUM_BP    = 4,
  parameter int AW        = 24,
  parameter int DW        = 8,
  parameter int RAW       = 8,
  parameter int CTRL_ADDR = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [RAW-1:0]             wr_addr_i,
  input  logic [DW-1:0]              wr_data_i,
  output logic [NUM_BP-1:0][AW-1:0]  bp_addr_o,
  output logic [NUM_BP-1:0]          bp_en_o
);
  localparam int BYTES  = AW / DW;
  localparam int SLOT_W = $clog2(BYTES);
  localparam int STRIDE = 1 << SLOT_W;

  logic [DW-1:0] byte_q [NUM_BP][BYTES];
  logic [NUM_BP-1:0] en_q;

  // breakpoint bytes carry no reset; enables gate them until loaded
  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      for (int x = 0; x < NUM_BP; x++) begin
        for (int b = 0; b < BYTES; b++) begin
          if (wr_addr_i == RAW'(x * STRIDE + b)) byte_q[x][b] <= wr_data_i;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= '0;
    else if (wr_en_i && wr_addr_i == RAW'(CTRL_ADDR)) en_q <= wr_data_i[NUM_BP-1:0];
  end

  always_comb begin
    for (int x = 0; x < NUM_BP; x++) begin
      for (int b = 0; b < BYTES; b++) begin
        bp_addr_o[x][b*DW +: DW] = byte_q[x][b];
      end
    end
  end

  assign bp_en_o = en_q;
endmodule

// File: rtl/bp_eff_addr.sv
module bp_eff_addr
  import bp_pkg::*;
#(
  parameter int AW     = 24,
  parameter int BASE_W = 8
) (
  input  logic              mode_i,
  input  logic [BASE_W-1:0] base_i,
  input  logic [AW-1:0]     addr_i,
  output logic [AW-1:0]     eff_o
);
  localparam int LOW_W = AW - BASE_W;

  always_comb begin
    unique case (addr_mode_e'(mode_i))
      MODE_FULL24: eff_o = addr_i;
      default:     eff_o = {base_i, addr_i[LOW_W-1:0]};
    endcase
  end
endmodule

// File: rtl/bp_match.sv
module bp_match #(
  parameter int NUM_BP = 4,
  parameter int AW     = 24
) (
  input  logic                      valid_i,
  input  logic [AW-1:0]             eff_i,
  input  logic [NUM_BP-1:0][AW-1:0] bp_addr_i,
  input  logic [NUM_BP-1:0]         bp_en_i,
  output logic [NUM_BP-1:0]         hit_o
);
  for (genvar x = 0; x < NUM_BP; x++) begin : g_cmp
    assign hit_o[x] = valid_i && bp_en_i[x] && (eff_i == bp_addr_i[x]);
  end
endmodule

// File: rtl/bp_brk_ctl.sv
module bp_brk_ctl #(
  parameter int NUM_BP = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              fetch_i,
  input  logic              iend_i,
  input  logic [NUM_BP-1:0] hit_i,
  output logic              brk_o,
  output logic [NUM_BP-1:0] hit_o,
  output logic              pend_o
);
  logic any_hit, imm_brk, defer_hit, brk_d, pend_d;
  logic brk_q, pend_q;
  logic [NUM_BP-1:0] hit_q;

  assign any_hit   = |hit_i;
  assign imm_brk   = valid_i && fetch_i && any_hit;
  assign defer_hit = valid_i && !fetch_i && any_hit;
  assign brk_d     = imm_brk || (iend_i && (pend_q || defer_hit));
  // any issued break consumes the pending request
  assign pend_d    = brk_d ? 1'b0 : (pend_q || defer_hit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      brk_q  <= 1'b0;
      pend_q <= 1'b0;
      hit_q  <= '0;
    end else begin
      brk_q  <= brk_d;
      pend_q <= pend_d;
      hit_q  <= valid_i ? hit_i : '0;
    end
  end

  assign brk_o  = brk_q;
  assign hit_o  = hit_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/addr_bp_unit.sv
module addr_bp_unit #(
  parameter int NUM_BP    = 4,
  parameter int AW        = 24,
  parameter int DW        = 8,
  parameter int RAW       = 8,
  parameter int BASE_W    = 8,
  parameter int CTRL_ADDR = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [RAW-1:0]    wr_addr_i,
  input  logic [DW-1:0]     wr_data_i,
  input  logic              bus_valid_i,
  input  logic              opfetch_i,
  input  logic              instr_end_i,
  input  logic              mode_i,
  input  logic [BASE_W-1:0] mbase_i,
  input  logic [AW-1:0]     addr_i,
  output logic              brk_o,
  output logic [NUM_BP-1:0] hit_o
);
  logic [NUM_BP-1:0][AW-1:0] bp_addr;
  logic [NUM_BP-1:0]         bp_en;
  logic [AW-1:0]             eff_addr;
  logic [NUM_BP-1:0]         match_vec;
  logic                      pend_q;

  bp_regs #(
    .NUM_BP(NUM_BP), .AW(AW), .DW(DW), .RAW(RAW), .CTRL_ADDR(CTRL_ADDR)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .bp_addr_o(bp_addr), .bp_en_o(bp_en)
  );

  bp_eff_addr #(.AW(AW), .BASE_W(BASE_W)) u_eff (
    .mode_i(mode_i), .base_i(mbase_i), .addr_i(addr_i), .eff_o(eff_addr)
  );

  bp_match #(.NUM_BP(NUM_BP), .AW(AW)) u_match (
    .valid_i(bus_valid_i), .eff_i(eff_addr), .bp_addr_i(bp_addr),
    .bp_en_i(bp_en), .hit_o(match_vec)
  );

  bp_brk_ctl #(.NUM_BP(NUM_BP)) u_ctl (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(bus_valid_i), .fetch_i(opfetch_i),
    .iend_i(instr_end_i), .hit_i(match_vec), .brk_o(brk_o), .hit_o(hit_o),
    .pend_o(pend_q)
  );
endmodule

// File: rtl/addr_bp_chk.sv
module addr_bp_chk #(
  parameter int NUM_BP = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_valid_i,
  input logic              opfetch_i,
  input logic              instr_end_i,
  input logic              brk_o,
  input logic [NUM_BP-1:0] hit_o,
  input logic [NUM_BP-1:0] bp_en,
  input logic [NUM_BP-1:0] match_vec,
  input logic              pend_q
);
  AST_HIT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_valid_i |=> hit_o == '0); // R11

  AST_HIT_ENABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o != '0) |-> ((hit_o & ~$past(bp_en)) == '0)); // R3

  AST_FETCH_BRK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_i && opfetch_i && (match_vec != '0)) |=> brk_o); // R6

  AST_DEFER_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_valid_i && !opfetch_i && (match_vec != '0) && !instr_end_i) |=> (pend_q && !brk_o)); // R7

  AST_NO_SPURIOUS_BRK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!instr_end_i && !(bus_valid_i && opfetch_i)) |=> !brk_o); // R7

  AST_PEND_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_o |-> !pend_q); // R8
endmodule

bind addr_bp_unit addr_bp_chk #(.NUM_BP(NUM_BP)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bus_valid_i(bus_valid_i), .opfetch_i(opfetch_i),
  .instr_end_i(instr_end_i), .brk_o(brk_o), .hit_o(hit_o), .bp_en(bp_en),
  .match_vec(match_vec), .pend_q(pend_q)
);

// File: tb/tb_addr_bp_unit.sv
module tb_addr_bp_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [7:0]  wr_addr_i = '0;
  logic [7:0]  wr_data_i = '0;
  logic        bus_valid_i = 1'b0;
  logic        opfetch_i = 1'b0;
  logic        instr_end_i = 1'b0;
  logic        mode_i = 1'b1;
  logic [7:0]  mbase_i = '0;
  logic [23:0] addr_i = '0;
  logic        brk_o;
  logic [3:0]  hit_o;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_bp_unit dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .bus_valid_i(bus_valid_i), .opfetch_i(opfetch_i),
    .instr_end_i(instr_end_i), .mode_i(mode_i), .mbase_i(mbase_i), .addr_i(addr_i),
    .brk_o(brk_o), .hit_o(hit_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic load_bp(input int x, input logic [23:0] a);
    wr(8'(4*x + 0), a[7:0]);
    wr(8'(4*x + 1), a[15:8]);
    wr(8'(4*x + 2), a[23:16]);
  endtask

  // one bus cycle; outputs reflect it when the task returns
  task automatic acc(input logic v, input logic f, input logic m, input logic [7:0] mb,
                     input logic [23:0] a, input logic ie);
    bus_valid_i = v; opfetch_i = f; mode_i = m; mbase_i = mb; addr_i = a; instr_end_i = ie;
    @(negedge clk);
    bus_valid_i = 1'b0; opfetch_i = 1'b0; instr_end_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 brk after reset", 32'(brk_o), 0);
    chk("R1 hit after reset", 32'(hit_o), 0);
    load_bp(0, 24'h123456);
    acc(1, 1, 1, 8'h00, 24'h123456, 0);
    chk("R1 disabled brk", 32'(brk_o), 0);
    chk("R1 disabled hit", 32'(hit_o), 0);
  endtask

  task automatic t_fetch24();
    wr(8'h10, 8'h01);
    acc(1, 1, 1, 8'h77, 24'h123456, 0);
    chk("R6 fetch brk", 32'(brk_o), 1);
    chk("R4 R11 hit", 32'(hit_o), 1);
    acc(0, 0, 1, 8'h00, 24'h123456, 0);
    chk("R6 one cycle", 32'(brk_o), 0);
    chk("R11 R12 idle hit", 32'(hit_o), 0);
    acc(1, 1, 1, 8'h00, 24'h123457, 0);
    chk("R2 low byte miss", 32'(hit_o), 0);
    acc(1, 1, 1, 8'h00, 24'h123556, 0);
    chk("R2 high byte miss", 32'(hit_o), 0);
    acc(1, 1, 1, 8'h12, 24'h023456, 0);
    chk("R2 R4 upper byte miss", 32'(brk_o), 0);
    acc(0, 1, 1, 8'h00, 24'h123456, 1);
    chk("R12 no valid brk", 32'(brk_o), 0);
    chk("R12 no valid hit", 32'(hit_o), 0);
  endtask

  task automatic t_mode16();
    load_bp(1, 24'hAB1234);
    wr(8'h10, 8'h03);
    acc(1, 1, 0, 8'hAB, 24'hFF1234, 0);
    chk("R5 base match hit", 32'(hit_o), 2);
    chk("R5 base match brk", 32'(brk_o), 1);
    acc(1, 1, 0, 8'hAC, 24'hAB1234, 0);
    chk("R5 base miss", 32'(hit_o), 0);
    acc(1, 1, 1, 8'hAB, 24'hFF1234, 0);
    chk("R4 full mode ignores base", 32'(hit_o), 0);
  endtask

  task automatic t_defer();
    acc(1, 0, 1, 8'h00, 24'h123456, 0);
    chk("R7 no early brk", 32'(brk_o), 0);
    chk("R7 hit on data access", 32'(hit_o), 1);
    acc(0, 0, 1, 8'h00, 24'h0, 0);
    chk("R7 still pending", 32'(brk_o), 0);
    acc(0, 0, 1, 8'h00, 24'h0, 1);
    chk("R7 brk at end", 32'(brk_o), 1);
    acc(0, 0, 1, 8'h00, 24'h0, 1);
    chk("R8 pending cleared", 32'(brk_o), 0);
    acc(1, 0, 1, 8'h00, 24'h123456, 1);
    chk("R7 same-cycle end", 32'(brk_o), 1);
    acc(0, 0, 1, 8'h00, 24'h0, 1);
    chk("R8 no repeat", 32'(brk_o), 0);
  endtask

  task automatic t_multi();
    load_bp(2, 24'h00C0DE);
    load_bp(3, 24'h00C0DE);
    wr(8'h10, 8'h0F);
    acc(1, 1, 1, 8'h00, 24'h00C0DE, 0);
    chk("R9 both hits", 32'(hit_o), 32'hC);
    chk("R9 brk", 32'(brk_o), 1);
    acc(0, 0, 1, 8'h00, 24'h0, 0);
    chk("R9 single pulse", 32'(brk_o), 0);
    wr(8'h10, 8'hF4);
    acc(1, 1, 1, 8'h00, 24'h00C0DE, 0);
    chk("R3 high data bits dropped", 32'(hit_o), 32'h4);
  endtask

  task automatic t_unmapped();
    wr(8'h10, 8'h0F);
    wr(8'h03, 8'h00); wr(8'h07, 8'h00); wr(8'h0B, 8'h00); wr(8'h0F, 8'h00);
    wr(8'h11, 8'h00); wr(8'h30, 8'h00); wr(8'h90, 8'h00); wr(8'h40, 8'h00);
    acc(1, 1, 1, 8'h00, 24'h123456, 0);
    chk("R10 bp0 kept", 32'(hit_o), 1);
    acc(1, 1, 0, 8'hAB, 24'h001234, 0);
    chk("R10 bp1 kept", 32'(hit_o), 2);
    acc(1, 1, 1, 8'h00, 24'h00C0DE, 0);
    chk("R10 bp2 bp3 kept", 32'(hit_o), 32'hC);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_fetch24();
    t_mode16();
    t_defer();
    t_multi();
    t_unmapped();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule